// File: doc/BRIEF.md
# Length-Prefixed SPI Frame Master

This block is an SPI master that moves whole frames between a local byte buffer and one slave. Each frame starts with a 16-bit byte count, sent high byte first, and the payload follows. The bus runs in mode 0: the clock idles low, the slave samples on the rising edge, and SCK is the system clock divided by `SCK_DIV` (4 by default). After every byte the engine waits `GAP_CYCLES` clock cycles before it starts the next one, which gives a slow slave time to handle each byte.

A transmit request takes a payload length. The engine sends the two header bytes and then reads the payload from the local buffer, one byte at a time, through a read port that answers in the same cycle. A fetch request takes a buffer capacity. The engine clocks out 0xFF filler bytes and takes the payload length from the first two bytes it receives. Each payload byte goes to the local buffer through a write port. Bytes at or beyond the capacity are still clocked on the bus but are not written.

After reset the engine pulls slave-select low and waits `STARTUP_CYCLES` before it accepts a request. A request made before then, or while a frame is running, gets a one-cycle error pulse and changes nothing. The buffer ports have no back-pressure. The read port must return data in the same cycle its enable is high. The write port must accept every write strobe.

Top module: `spi_frame_master`

## Requirements
- R1: SCK is low when idle. Each SCK level lasts at least two system clocks (default period 4 clocks). MOSI does not change while SCK is high.
- R2: A transmit frame sends the length high byte, then the length low byte, then payload bytes in read address order 0, 1, 2, and so on.
- R3: When a transmit completes, `done_count` equals the requested payload length, without the two header bytes.
- R4: Every byte shifted out during a fetch is 0xFF.
- R5: In a fetch, received byte 0 is bits 15:8 of the length and byte 1 is bits 7:0. The frame ends after exactly that many payload bytes, and payload byte k is written to address k.
- R6: In a fetch, a payload byte whose index is at or above the capacity is clocked but not written. `done_count` reports the announced length.
- R7: A fetch that announces length 0 ends after the two header bytes and reports 0.
- R8: Between the end of one byte and the start of the next, at least `GAP_CYCLES` clocks pass.
- R9: A request while a frame is in progress raises `cmd_err` for one cycle. The running frame continues unchanged.
- R10: While reset is active `ss_n` is high. After reset `ss_n` goes low. Requests made before `STARTUP_CYCLES` have elapsed are rejected with `cmd_err`.
- R11: `done` is a single-cycle pulse. `done_count` holds its value until the next frame finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Request strobe, one cycle |
| cmd_fetch | input | 1 | 1 = fetch, 0 = transmit |
| cmd_len | input | 16 | Transmit: payload length. Fetch: buffer capacity |
| cmd_err | output | 1 | Request rejected (pulse) |
| tx_rd_en | output | 1 | Payload read strobe |
| tx_rd_addr | output | 16 | Payload read address |
| tx_rd_data | input | 8 | Payload byte, valid in the same cycle |
| rx_wr_en | output | 1 | Payload write strobe |
| rx_wr_addr | output | 16 | Payload write address |
| rx_wr_data | output | 8 | Payload byte to store |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| ss_n | output | 1 | Slave select, active low |
| done | output | 1 | Frame complete (pulse) |
| done_count | output | 16 | Payload bytes in the last frame |

## Verification
Transmit frames use random payloads and lengths, including zero and a length above 255, so the header's high byte is nonzero and a swapped or missing header byte shows up. Fetch frames use an announced length below, equal to and above the capacity. This separates "clocked but dropped" from "not clocked at all" and shows whether `done_count` reports the announced length or the number of bytes stored. A zero-length fetch checks that the end test fires right after the header. Requests during startup and during a running frame show that a rejected request leaves the byte stream unchanged. The low time between bytes is measured on `sck` to check the gap.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int HDR_BYTES = 2;
  localparam int LEN_W     = 8 * HDR_BYTES;
  localparam int CNT_W     = LEN_W + 1;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    FS_BOOT  = 2'd0,
    FS_IDLE  = 2'd1,
    FS_XMIT  = 2'd2,
    FS_FETCH = 2'd3
  } frame_state_e;
endpackage

// File: rtl/spi_wait_timer.sv
module spi_wait_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic fire
);
  localparam int W = $clog2(LIMIT + 1) + 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= W'(LIMIT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign fire    = (cnt_q == W'(1));
  assign running = (cnt_q > W'(1));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int PH_W = $clog2(SCK_DIV);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SCK_DIV / 2 - 1);
  localparam logic [PH_W-1:0] PH_HIGH   = PH_W'(SCK_DIV / 2);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SCK_DIV - 1);

  logic            busy_q, done_q;
  logic [PH_W-1:0] ph_q;
  logic [2:0]      bit_q;
  logic [7:0]      txs_q, rxs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          ph_q   <= '0;
          bit_q  <= '0;
          txs_q  <= tx_byte;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
        if (ph_q == PH_SAMPLE) rxs_q <= {rxs_q[6:0], miso};
        if (ph_q == PH_LAST) begin
          ph_q <= '0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            txs_q <= {txs_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck     = busy_q && (ph_q >= PH_HIGH);
  assign mosi    = txs_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rxs_q;

  // R1
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R1
  sck_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> sck);
  // R1
  sck_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |=> !sck);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int          SCK_DIV        = 4,
  parameter int unsigned GAP_CYCLES     = 20000,
  parameter int unsigned STARTUP_CYCLES = 20000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_fetch,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             cmd_err,
  output logic             tx_rd_en,
  output logic [LEN_W-1:0] tx_rd_addr,
  input  logic [7:0]       tx_rd_data,
  output logic             rx_wr_en,
  output logic [LEN_W-1:0] rx_wr_addr,
  output logic [7:0]       rx_wr_data,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n,
  output logic             done,
  output logic [LEN_W-1:0] done_count
);
  frame_state_e     st_q;
  logic [CNT_W-1:0] cnt_q, pay_idx, total;
  logic [LEN_W-1:0] len_q, cap_q, dcount_q;
  logic             boot_kick_q, ss_q, err_q, done_q;

  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       gap_run, gap_fire, boot_run, boot_fire;
  logic       accept, in_frame, at_end, cont;

  spi_byte_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
  );

  spi_wait_timer #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(sh_done), .running(gap_run), .fire(gap_fire)
  );

  spi_wait_timer #(.LIMIT(STARTUP_CYCLES)) u_boot (
    .clk(clk), .rst_n(rst_n), .start(boot_kick_q), .running(boot_run), .fire(boot_fire)
  );

  always_comb begin
    accept   = cmd_start && (st_q == FS_IDLE);
    in_frame = (st_q == FS_XMIT) || (st_q == FS_FETCH);
    total    = {1'b0, len_q} + CNT_W'(HDR_BYTES);
    pay_idx  = cnt_q - CNT_W'(HDR_BYTES);
    at_end   = (cnt_q >= CNT_W'(HDR_BYTES)) && (cnt_q == total);
    cont     = gap_fire && in_frame && !at_end;
    sh_start = accept || cont;

    if (accept)                  sh_tx = cmd_fetch ? FILL_BYTE : cmd_len[LEN_W-1 -: 8];
    else if (st_q == FS_FETCH)   sh_tx = FILL_BYTE;
    else if (cnt_q == CNT_W'(1)) sh_tx = len_q[7:0];
    else                         sh_tx = tx_rd_data;

    tx_rd_en   = cont && (st_q == FS_XMIT) && (cnt_q >= CNT_W'(HDR_BYTES));
    tx_rd_addr = pay_idx[LEN_W-1:0];

    rx_wr_en   = sh_done && (st_q == FS_FETCH) && (cnt_q >= CNT_W'(HDR_BYTES))
                 && (pay_idx < {1'b0, cap_q});
    rx_wr_addr = pay_idx[LEN_W-1:0];
    rx_wr_data = sh_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= FS_BOOT;
      cnt_q       <= '0;
      len_q       <= '0;
      cap_q       <= '0;
      dcount_q    <= '0;
      boot_kick_q <= 1'b1;
      ss_q        <= 1'b1;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      boot_kick_q <= 1'b0;
      ss_q        <= 1'b0;
      err_q       <= cmd_start && !accept;
      done_q      <= 1'b0;
      case (st_q)
        FS_BOOT: if (boot_fire) st_q <= FS_IDLE;
        FS_IDLE: if (accept) begin
          st_q  <= cmd_fetch ? FS_FETCH : FS_XMIT;
          cnt_q <= '0;
          len_q <= cmd_fetch ? '0 : cmd_len;
          cap_q <= cmd_len;
        end
        default: begin
          if (sh_done) begin
            cnt_q <= cnt_q + 1'b1;
            if (st_q == FS_FETCH) begin
              if (cnt_q == CNT_W'(0)) len_q[LEN_W-1:8] <= sh_rx;
              if (cnt_q == CNT_W'(1)) len_q[7:0]       <= sh_rx;
            end
          end
          if (gap_fire && at_end) begin
            st_q     <= FS_IDLE;
            done_q   <= 1'b1;
            dcount_q <= len_q;
          end
        end
      endcase
    end
  end

  assign cmd_err    = err_q;
  assign ss_n       = ss_q;
  assign done       = done_q;
  assign done_count = dcount_q;

  // R8
  gap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> (!gap_run && !sh_busy));
  // R9
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && in_frame && !gap_fire) |=> (st_q == $past(st_q)));
  // R10
  boot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && st_q == FS_BOOT) |=> cmd_err);
  // R10
  select_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_BOOT) |-> !ss_n);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  write_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en |-> (st_q == FS_FETCH && !boot_run));
endmodule

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
  localparam int GAP  = 8;
  localparam int BOOT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_start = 1'b0, cmd_fetch = 1'b0;
  logic [15:0] cmd_len = '0;
  logic        cmd_err, tx_rd_en, rx_wr_en, sck, mosi, miso, ss_n, done;
  logic [15:0] tx_rd_addr, rx_wr_addr, done_count;
  logic [7:0]  tx_rd_data, rx_wr_data;

  spi_frame_master #(.SCK_DIV(4), .GAP_CYCLES(GAP), .STARTUP_CYCLES(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_fetch(cmd_fetch),
    .cmd_len(cmd_len), .cmd_err(cmd_err), .tx_rd_en(tx_rd_en), .tx_rd_addr(tx_rd_addr),
    .tx_rd_data(tx_rd_data), .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr),
    .rx_wr_data(rx_wr_data), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .done(done), .done_count(done_count)
  );

  logic [7:0] tx_mem [0:255];
  assign tx_rd_data = tx_mem[tx_rd_addr[7:0]];

  // slave model
  logic [7:0] resp [0:511];
  logic [7:0] mlog [0:511];
  logic [8:0] slv_byte = '0;
  logic [2:0] slv_bit = '0;
  logic [7:0] slv_in = '0;
  int         mlog_n = 0;
  assign miso = resp[slv_byte][3'd7 - slv_bit];

  always @(posedge sck) begin
    if (slv_bit == 3'd7) begin
      if (mlog_n < 512) mlog[mlog_n] = {slv_in[6:0], mosi};
      mlog_n   = mlog_n + 1;
      slv_byte = slv_byte + 1'b1;
      slv_bit  = '0;
    end else begin
      slv_in  = {slv_in[6:0], mosi};
      slv_bit = slv_bit + 1'b1;
    end
  end

  // write-port monitor
  logic [7:0] rx_mem [0:511];
  int wr_n = 0, bad_wr = 0, cur_cap = 0;
  always @(posedge clk) begin
    if (rx_wr_en) begin
      rx_mem[rx_wr_addr[8:0]] = rx_wr_data;
      wr_n = wr_n + 1;
      if (int'(rx_wr_addr) >= cur_cap) bad_wr = bad_wr + 1;
    end
  end

  // inter-byte low time monitor
  logic prev_sck = 1'b0;
  int low_run = 0, rises = 0, min_gap = 1000000;
  always @(posedge clk) begin
    if (sck && !prev_sck) begin
      if (rises != 0 && (rises % 8) == 0 && low_run < min_gap) min_gap = low_run;
      rises   = rises + 1;
      low_run = 0;
    end else if (!sck) begin
      low_run = low_run + 1;
    end
    prev_sck = sck;
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] exp_tx(input int idx, input int len);
    if (idx == 0)      return 8'(len >> 8);
    else if (idx == 1) return 8'(len);
    else               return tx_mem[(idx - 2) % 256];
  endfunction

  task automatic slave_clear();
    slv_byte = '0; slv_bit = '0; slv_in = '0; mlog_n = 0; rises = 0;
  endtask

  task automatic issue(input bit f, input int l, output bit err);
    @(negedge clk);
    cmd_start = 1'b1; cmd_fetch = f; cmd_len = 16'(l);
    @(negedge clk);
    err = cmd_err;
    cmd_start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 40000 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_tx(input int len, input bit poke);
    bit e, seen;
    int mism;
    for (int i = 0; i < 256; i++) tx_mem[i] = 8'($urandom);
    for (int i = 0; i < 512; i++) resp[i] = 8'($urandom);
    slave_clear();
    issue(1'b0, len, e);
    chk(!e, "R9 accepted tx", int'(e), 0);
    if (poke) begin
      repeat (50) @(negedge clk);
      issue(1'b1, 5, e);
      chk(e, "R9 busy reject", int'(e), 1);
    end
    wait_done(seen);
    chk(seen, "R3 tx done seen", int'(seen), 1);
    chk(done_count == 16'(len), "R3 tx count", int'(done_count), len);
    chk(mlog_n == len + 2, "R2 tx byte total", mlog_n, len + 2);
    mism = 0;
    for (int i = 0; i < len + 2 && i < 512; i++) if (mlog[i] != exp_tx(i, len)) mism++;
    chk(mism == 0, "R2 tx byte order mismatches", mism, 0);
    @(negedge clk);
    chk(!done, "R11 done width", int'(done), 0);
    repeat (15) @(negedge clk);
    chk(done_count == 16'(len), "R11 count held", int'(done_count), len);
  endtask

  task automatic run_fetch(input int ann, input int cap, input string tag);
    bit e, seen;
    int mism, ffbad, stored;
    resp[0] = 8'(ann >> 8);
    resp[1] = 8'(ann);
    for (int i = 2; i < 512; i++) resp[i] = 8'($urandom);
    for (int i = 0; i < 512; i++) rx_mem[i] = 8'h00;
    wr_n = 0; bad_wr = 0; cur_cap = cap;
    slave_clear();
    issue(1'b1, cap, e);
    chk(!e, "R9 accepted fetch", int'(e), 0);
    wait_done(seen);
    chk(seen, {tag, " fetch done seen"}, int'(seen), 1);
    chk(done_count == 16'(ann), {tag, " R5 R6 fetch count"}, int'(done_count), ann);
    chk(mlog_n == ann + 2, {tag, " R5 bytes clocked"}, mlog_n, ann + 2);
    ffbad = 0;
    for (int i = 0; i < mlog_n && i < 512; i++) if (mlog[i] != 8'hFF) ffbad++;
    chk(ffbad == 0, "R4 filler bytes not 0xFF", ffbad, 0);
    stored = (ann < cap) ? ann : cap;
    chk(wr_n == stored, "R6 writes made", wr_n, stored);
    chk(bad_wr == 0, "R6 writes beyond capacity", bad_wr, 0);
    mism = 0;
    for (int i = 0; i < stored && i < 510; i++) if (rx_mem[i] != resp[i + 2]) mism++;
    chk(mism == 0, "R5 stored payload mismatches", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    bit e;
    int seed;
    seed = int'($urandom(32'h1F2E));
    repeat (4) @(negedge clk);
    chk(ss_n, "R10 ss_n in reset", int'(ss_n), 1);
    chk(!sck, "R1 sck idle in reset", int'(sck), 0);
    chk(!done, "R11 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ss_n, "R10 ss_n low after reset", int'(ss_n), 0);
    issue(1'b0, 3, e);
    chk(e, "R10 startup reject", int'(e), 1);
    repeat (BOOT + 10) @(negedge clk);
    chk(!sck, "R1 sck idle", int'(sck), 0);

    run_tx(0, 1'b0);
    run_tx(5, 1'b1);
    run_tx(260, 1'b0);
    run_fetch(0, 4, "R7 zero length");
    run_fetch(6, 3, "R6 overflow");
    run_fetch(4, 4, "R5 exact fit");
    run_fetch(258, 300, "R5 high byte");
    for (int k = 0; k < 10; k++) begin
      if ($urandom % 2 == 0) run_tx(int'($urandom % 24), ($urandom % 3) == 0);
      else run_fetch(int'($urandom % 24), int'($urandom % 30), "R5 random");
    end
    chk(min_gap >= GAP, "R8 inter-byte low time", min_gap, GAP);
    summary();
  end
endmodule